// File: doc/BRIEF.md
# Clock Divider Change Sequencer

This block owns the display clock divider register and moves it to a newly requested value. Most changes are a plain register write. A step between divider 126 and divider 127 changes the clock rate too much for the pixel FIFOs to absorb, so the block compensates before the write. It takes one FIFO fill reading and sets the FIFO error-detect override. It then pulses the timing generator to drop or add pixels, clears the override, and only then writes the divider.

A request is a target value on `target_i` with a one-cycle `start_i` strobe while `busy_o` is low. The block uses the drop path whenever the register currently holds 127 and the target is anything else. The add path is used only from 126. A request for 127 from any other value first writes 126 and then runs the add path. `done_o` pulses once when the register holds the target.

Top module: `clkdiv_step_seq`

## Requirements
- R1: After reset, `div_o` is 126 and `busy_o`, `done_o`, `ovr_en_o`, `drop_px_o` and `add_px_o` are all low.
- R2: A request that involves neither leaving 127 nor entering 127 loads `div_o` with the target at the strobe's clock edge. `done_o` is high in the cycle that follows, and `ovr_en_o` never rises.
- R3: A compensated step reads `fifo_level_i` one cycle after the strobe and derives N as the level shifted right by two bits, which is floor(level/4).
- R4: When leaving 127 for any other value, the block issues max(N−4, 0) drop pulses and no add pulses, then writes the target.
- R5: When going from 126 to 127, the block issues max(12−N, 0) add pulses and no drop pulses, then writes 127.
- R6: A request for 127 from a value other than 126 shows 126 on `div_o` in the cycle after the strobe. It then runs the add path of R5 and ends at 127.
- R7: Pulses appear only while `ovr_en_o` is high. `div_o` does not change while `ovr_en_o` is high. `ovr_en_o` is set and cleared even when the pulse count is zero, and it is low whenever `busy_o` is low.
- R8: Each drop or add pulse is one cycle wide, at least one low cycle separates two pulses, and the two pulse outputs are never high together.
- R9: `busy_o` rises in the cycle after an accepted strobe. A strobe that arrives while `busy_o` is high is ignored, and it changes neither the final divider nor the pulse counts.
- R10: `done_o` is high for exactly one cycle, with `busy_o` still high, and `busy_o` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, accepted only while idle |
| target_i | input | 7 | Requested divider value |
| fifo_level_i | input | 8 | Average pixel FIFO fill level |
| div_o | output | 7 | Divider register value |
| ovr_en_o | output | 1 | FIFO error-detect override enable |
| drop_px_o | output | 1 | One-cycle drop-pixel pulse to the timing generator |
| add_px_o | output | 1 | One-cycle add-pixel pulse to the timing generator |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every output is registered, and the bench samples on falling edges.

- **Direct write:** the new divider and `done_o` both appear at the first falling edge after the strobe's rising edge, and the bench checks them there.
- **Compensated step:** the first sample after the strobe must already show `busy_o`, and 126 when the intermediate write applies. Over the following cycles the override rises, k pulses follow two cycles apart, and the override falls. The divider write and `done_o` follow the override in consecutive cycles, about 2k+4 cycles in all.
- **Cycle records:** the bench keeps a record of every cycle up to `done_o`. From it, the bench checks pulse counts, pulse spacing, override framing and divider stability. It then checks the idle state in the next cycle and once more after a strobe sent during the `done_o` cycle.

// File: rtl/clkdiv_step_seq.sv
module clkdiv_step_seq #(
  parameter int DIV_W      = 7,
  parameter int LVL_W      = 8,
  parameter int DIV_RST    = 126,
  parameter int DIV_LO     = 126,
  parameter int DIV_HI     = 127,
  parameter int LVL_SHIFT  = 2,
  parameter int DROP_BIAS  = 4,
  parameter int ADD_TARGET = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] target_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  output logic [DIV_W-1:0] div_o,
  output logic             ovr_en_o,
  output logic             drop_px_o,
  output logic             add_px_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam logic [DIV_W-1:0] LO   = DIV_W'(DIV_LO);
  localparam logic [DIV_W-1:0] HI   = DIV_W'(DIV_HI);
  localparam logic [LVL_W-1:0] BIAS = LVL_W'(DROP_BIAS);
  localparam logic [LVL_W-1:0] TOP  = LVL_W'(ADD_TARGET);

  typedef enum logic [2:0] {
    S_IDLE, S_SAMPLE, S_PULSE, S_GAP, S_OVR_OFF, S_WRITE, S_DONE
  } state_t;

  state_t           state_q;
  logic [DIV_W-1:0] div_q, pend_q;
  logic [LVL_W-1:0] cnt_q;
  logic             add_mode_q, ovr_q, drop_q, add_q;

  wire at_hi    = (div_q == HI);
  wire to_hi    = (target_i == HI);
  wire leave_hi = at_hi && !to_hi;
  wire enter_hi = to_hi && !at_hi;
  wire need_lo  = enter_hi && (div_q != LO);

  wire [LVL_W-1:0] lvl_n  = fifo_level_i >> LVL_SHIFT;
  wire [LVL_W-1:0] drop_n = (lvl_n > BIAS) ? lvl_n - BIAS : '0;
  wire [LVL_W-1:0] add_n  = (lvl_n < TOP)  ? TOP - lvl_n  : '0;
  wire [LVL_W-1:0] seq_n  = add_mode_q ? add_n : drop_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      div_q      <= DIV_W'(DIV_RST);
      pend_q     <= '0;
      cnt_q      <= '0;
      add_mode_q <= 1'b0;
      ovr_q      <= 1'b0;
      drop_q     <= 1'b0;
      add_q      <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          pend_q     <= target_i;
          add_mode_q <= enter_hi;
          if (leave_hi || enter_hi) begin
            if (need_lo) div_q <= LO;
            state_q <= S_SAMPLE;
          end else begin
            div_q   <= target_i;
            state_q <= S_DONE;
          end
        end
        S_SAMPLE: begin
          ovr_q   <= 1'b1;
          cnt_q   <= seq_n;
          state_q <= (seq_n == '0) ? S_OVR_OFF : S_PULSE;
        end
        S_PULSE: begin
          if (add_mode_q) add_q <= 1'b1;
          else            drop_q <= 1'b1;
          cnt_q   <= cnt_q - 1'b1;
          state_q <= S_GAP;
        end
        S_GAP: begin
          add_q   <= 1'b0;
          drop_q  <= 1'b0;
          state_q <= (cnt_q == '0) ? S_OVR_OFF : S_PULSE;
        end
        S_OVR_OFF: begin
          ovr_q   <= 1'b0;
          state_q <= S_WRITE;
        end
        S_WRITE: begin
          div_q   <= pend_q;
          state_q <= S_DONE;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign div_o     = div_q;
  assign ovr_en_o  = ovr_q;
  assign drop_px_o = drop_q;
  assign add_px_o  = add_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);

endmodule

// File: rtl/clkdiv_step_seq_chk.sv
module clkdiv_step_seq_chk #(
  parameter int DIV_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [DIV_W-1:0] div_o,
  input logic             ovr_en_o,
  input logic             drop_px_o,
  input logic             add_px_o,
  input logic             busy_o,
  input logic             done_o
);

  AST_PULSE_UNDER_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_px_o || add_px_o) |-> ovr_en_o); // R7
  AST_DIV_HELD_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en_o |-> $stable(div_o)); // R7
  AST_IDLE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !ovr_en_o); // R7
  AST_DROP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    drop_px_o |=> !drop_px_o); // R8
  AST_ADD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    add_px_o |=> !add_px_o); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(drop_px_o && add_px_o)); // R8
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R9
  AST_IDLE_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(div_o)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R10
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o); // R10
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R10

endmodule

bind clkdiv_step_seq clkdiv_step_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_o(div_o),
  .ovr_en_o(ovr_en_o), .drop_px_o(drop_px_o), .add_px_o(add_px_o),
  .busy_o(busy_o), .done_o(done_o)
);

// File: tb/tb_clkdiv_step_seq.sv
`timescale 1ns/1ps
module tb_clkdiv_step_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] target_i = '0;
  logic [7:0] fifo_level_i = '0;
  logic [6:0] div_o;
  logic       ovr_en_o, drop_px_o, add_px_o, busy_o, done_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  clkdiv_step_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_i(target_i),
    .fifo_level_i(fifo_level_i), .div_o(div_o), .ovr_en_o(ovr_en_o),
    .drop_px_o(drop_px_o), .add_px_o(add_px_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Direct write: result due at the first falling edge after the strobe edge.
  task automatic run_direct(input int tgt);
    @(negedge clk);
    target_i = 7'(tgt);
    start_i  = 1'b1;
    @(negedge clk);
    start_i  = 1'b0;
    chk(done_o == 1'b1, "R2 done one cycle after strobe", int'(done_o), 1);
    chk(int'(div_o) == tgt, "R2 divider written directly", int'(div_o), tgt);
    chk(ovr_en_o == 1'b0, "R2 no override on direct write", int'(ovr_en_o), 0);
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R10 idle after done", int'(busy_o), 0);
  endtask

  // Compensated step, followed cycle by cycle until done.
  task automatic run_step(input int tgt, input int lvl, input int exp_add,
                          input int exp_drop, input bit mid_lo, input bit spam);
    int adds = 0, drops = 0, cyc = 0, ovr_cycles = 0;
    int bad_frame = 0, bad_gap = 0, div_moved = 0;
    bit prev_pulse = 1'b0, seen_done = 1'b0;
    logic [6:0] prev_div;
    @(negedge clk);
    target_i     = 7'(tgt);
    fifo_level_i = 8'(lvl);
    start_i      = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after accepted strobe", int'(busy_o), 1);
    if (mid_lo) chk(div_o == 7'd126, "R6 intermediate 126", int'(div_o), 126);
    prev_div = div_o;
    while (!seen_done && cyc < 400) begin
      if (add_px_o) adds++;
      if (drop_px_o) drops++;
      if ((add_px_o || drop_px_o) && !ovr_en_o) bad_frame++;
      if (prev_pulse && (add_px_o || drop_px_o)) bad_gap++;
      if (add_px_o && drop_px_o) bad_gap++;
      if (ovr_en_o) begin
        ovr_cycles++;
        if (div_o != prev_div) div_moved++;
      end
      prev_pulse = add_px_o || drop_px_o;
      prev_div   = div_o;
      if (done_o) begin
        seen_done = 1'b1;
        chk(int'(div_o) == tgt, "R4 R5 final divider at done", int'(div_o), tgt);
        if (spam) begin
          start_i  = 1'b1;
          target_i = 7'd9;
        end
      end else begin
        if (spam && cyc == 2) begin
          start_i  = 1'b1;
          target_i = 7'd5;
        end else begin
          start_i  = 1'b0;
          target_i = 7'(tgt);
        end
        cyc++;
        @(negedge clk);
      end
    end
    chk(seen_done, "R10 done reached", int'(seen_done), 1);
    chk(adds == exp_add, "R3 R5 add pulse count", adds, exp_add);
    chk(drops == exp_drop, "R3 R4 drop pulse count", drops, exp_drop);
    chk(bad_frame == 0, "R7 pulse outside override", bad_frame, 0);
    chk(ovr_cycles > 0, "R7 override asserted", ovr_cycles, 1);
    chk(div_moved == 0, "R7 divider moved under override", div_moved, 0);
    chk(bad_gap == 0, "R8 pulse spacing", bad_gap, 0);
    @(negedge clk);
    start_i  = 1'b0;
    target_i = 7'(tgt);
    chk(busy_o == 1'b0 && ovr_en_o == 1'b0, "R10 idle after done", int'(busy_o), 0);
    chk(int'(div_o) == tgt, "R9 late strobe ignored", int'(div_o), tgt);
    @(negedge clk);
    chk(busy_o == 1'b0 && int'(div_o) == tgt, "R9 still idle", int'(div_o), tgt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(div_o == 7'd126, "R1 reset divider", int'(div_o), 126);
    chk({busy_o, done_o, ovr_en_o, drop_px_o, add_px_o} == 5'b0, "R1 reset outputs low",
        int'({busy_o, done_o, ovr_en_o, drop_px_o, add_px_o}), 0);
    run_direct(50);
    run_step(127, 20, 7, 0, 1'b1, 1'b0);   // 50 -> 127, N=5
    run_step(126, 40, 0, 6, 1'b0, 1'b0);   // N=10
    run_step(127, 60, 0, 0, 1'b0, 1'b0);   // N=15, empty add phase
    run_step(30, 100, 0, 21, 1'b0, 1'b1);  // N=25, drop to arbitrary value
    run_direct(126);
    run_step(127, 0, 12, 0, 1'b0, 1'b1);   // N=0
    run_step(126, 16, 0, 0, 1'b0, 1'b0);   // N=4, empty drop phase
    run_direct(126);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule